// File: doc/BRIEF.md
# Ninth-Bit Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial transceiver. Each frame holds one low start bit, then 8 or 9 data bits sent least significant bit first, then one high stop bit. In the 9-bit formats the extra bit is either a value taken from a control input or even parity computed over the data byte. Bit timing comes from one of two sources. The first is an external tick input that pulses sixteen times per bit. The second is a fixed division of the system clock, giving 32 or 64 clocks per bit.

Software writes a byte through a one-cycle write strobe, and the frame goes out on the transmit pin. The receiver samples each bit sixteen times per bit time. It confirms the start bit at mid-bit and takes each data bit and the stop bit at mid-bit. A finished word moves from the shift register into a holding register, so the next word can be shifted in while software still has the previous one unread.

A read strobe releases the holding register. A stop bit sampled low marks the held word with a framing error. A word that completes while the holding register is still full is dropped, and the overrun flag is set.

Top module: `uart9_core`

## Requirements
- R1: After reset, `tx_pin` is 1, and `tx_busy`, `rx_valid`, `rx_ferr` and `rx_ovr` are all 0.
- R2: A transmitted frame is a 0 start bit, then the data bits LSb first, then a 1 stop bit. The frame is 10 bits long when `mode`=0 and 11 bits long when `mode`=1, 2 or 3. The ninth bit is sent between the data bits and the stop bit.
- R3: In the 9-bit formats, the ninth bit equals `nb_val` when `nb_par`=0. When `nb_par`=1 it equals the XOR of the 8 data bits (even parity).
- R4: With `mode`=0, 2 or 3, one bit lasts 16 pulses of `baud_tick`. With `mode`=1, one bit lasts 32 system clocks when `slow_sel`=0 and 64 system clocks when `slow_sel`=1.
- R5: A write strobe that arrives while `tx_busy`=1 is ignored: the frame in progress is unchanged and no further frame is sent.
- R6: A frame received with `rx_en`=1 sets `rx_valid`, with the data on `rx_data` and the ninth bit on `rx_bit9`. A `rd_en` pulse clears `rx_valid` on the next cycle.
- R7: While `rx_en`=0, no new reception starts and `rx_valid` stays 0.
- R8: A word can be shifted in while the previous word is held. If the held word is read before the new word completes, the new word is delivered with `rx_ovr`=0.
- R9: A stop bit sampled low sets `rx_ferr` together with the delivered word.
- R10: When a word completes while `rx_valid`=1 and no read happens in that cycle, the word is discarded, `rx_data` keeps the held value, and `rx_ovr` sets. `rd_en` clears `rx_ovr`.
- R11: Transmit and receive run at the same time without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0: 8-bit, external tick; 1: 9-bit, fixed rate; 2/3: 9-bit, external tick |
| slow_sel | input | 1 | Fixed-rate mode: 0 = 32 clocks per bit, 1 = 64 clocks per bit |
| nb_par | input | 1 | Ninth bit source: 0 = `nb_val`, 1 = even parity |
| nb_val | input | 1 | Programmed ninth-bit value |
| rx_en | input | 1 | Receive enable |
| baud_tick | input | 1 | External tick, 16 pulses per bit |
| wr_en | input | 1 | Transmit write strobe |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read strobe that releases the holding register |
| rx_pin | input | 1 | Serial receive line |
| tx_pin | output | 1 | Serial transmit line |
| tx_busy | output | 1 | A frame is being sent |
| rx_valid | output | 1 | The holding register contains an unread word |
| rx_data | output | 8 | Received data byte |
| rx_bit9 | output | 1 | Received ninth bit (0 in 8-bit mode) |
| rx_ferr | output | 1 | The held word had a low stop bit |
| rx_ovr | output | 1 | A word was lost because the holding register was full |

## Verification
Some behaviours are checked by assertions on every cycle:
- the transmit line stays high whenever no frame is in progress;
- a write during a frame leaves the transmit shift register unchanged;
- the receiver stays idle while disabled;
- the fixed-rate tick never fires on two cycles in a row;
- a read clears the valid flag;
- an overrun keeps the held byte and raises the flag.

The bench scenarios cover what a property cannot see. They decode every bit of the transmitted frames, check the ninth-bit values and even parity, and measure the exact bit length in clocks. They also cover receiving a frame while the previous word is read mid-frame, framing errors and simultaneous transmit and receive.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  localparam logic [1:0] MODE_8_EXT = 2'd0;
  localparam logic [1:0] MODE_9_FIX = 2'd1;
  localparam logic [1:0] MODE_9_EXT = 2'd2;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/uart9_baud.sv
module uart9_baud #(
  parameter int OVS       = 16,
  parameter int FAST_CLKS = 32,
  parameter int SLOW_CLKS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic fixed,
  input  logic slow,
  input  logic ext_tick,
  output logic tick
);
  localparam int DIV_F = FAST_CLKS / OVS;
  localparam int DIV_S = SLOW_CLKS / OVS;
  localparam int CW    = (DIV_S > 1) ? $clog2(DIV_S) : 1;
  localparam logic [CW-1:0] LAST_F = CW'(DIV_F - 1);
  localparam logic [CW-1:0] LAST_S = CW'(DIV_S - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          wrap;

  assign last = slow ? LAST_S : LAST_F;
  assign wrap = (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      if (!fixed || wrap) cnt <= '0;
      else                cnt <= cnt + 1'b1;
      tick <= fixed ? wrap : ext_tick;
    end
  end

  // fixed-rate tick spacing is at least two clocks
  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    (fixed && tick) |=> !tick);
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          nine,
  input  logic          b9,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          txd
);
  localparam int FW   = DW + 3;
  localparam int CNTW = $clog2(OVS);
  localparam int BW   = $clog2(FW + 1);
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(OVS - 1);

  logic [FW-1:0]   sh;
  logic [CNTW-1:0] cnt;
  logic [BW-1:0]   left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      txd  <= 1'b1;
      sh   <= '1;
      cnt  <= '0;
      left <= '0;
    end else if (!busy) begin
      cnt <= '0;
      if (wr_en) begin
        busy <= 1'b1;
        sh   <= {1'b1, (nine ? b9 : 1'b1), wr_data, 1'b0};
        left <= nine ? BW'(FW) : BW'(FW - 1);
      end
    end else if (tick) begin
      cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
      if (cnt == '0) begin
        txd  <= sh[0];
        sh   <= {1'b1, sh[FW-1:1]};
        left <= left - 1'b1;
      end
      if (cnt == CNT_LAST && left == '0) busy <= 1'b0;
    end
  end

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  assert_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && !tick) |=> $stable(sh));
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en,
  input  logic          nine,
  input  logic          rxd,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          bit9,
  output logic          ferr
);
  localparam int CNTW = $clog2(OVS);
  localparam int BW   = $clog2(DW + 2);
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(OVS - 1);
  localparam logic [CNTW-1:0] CNT_MID  = CNTW'(OVS / 2 - 1);

  logic            s1, s2;
  rx_state_t       st;
  logic [CNTW-1:0] cnt;
  logic [BW-1:0]   idx;
  logic [DW:0]     sh;
  logic [BW-1:0]   last_idx;

  assign last_idx = nine ? BW'(DW) : BW'(DW - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      idx  <= '0;
      sh   <= '0;
      done <= 1'b0;
      data <= '0;
      bit9 <= 1'b0;
      ferr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: begin
            cnt <= '0;
            if (en && !s2) st <= RX_START;
          end
          RX_START: begin
            if (cnt == CNT_MID) begin
              cnt <= '0;
              idx <= '0;
              st  <= s2 ? RX_IDLE : RX_DATA;
            end else cnt <= cnt + 1'b1;
          end
          RX_DATA: begin
            if (cnt == CNT_LAST) begin
              cnt <= '0;
              sh  <= {s2, sh[DW:1]};
              idx <= idx + 1'b1;
              if (idx == last_idx) st <= RX_STOP;
            end else cnt <= cnt + 1'b1;
          end
          RX_STOP: begin
            if (cnt == CNT_LAST) begin
              cnt  <= '0;
              done <= 1'b1;
              ferr <= !s2;
              data <= nine ? sh[DW-1:0] : sh[DW:1];
              bit9 <= nine ? sh[DW] : 1'b0;
              st   <= RX_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  assert_disabled_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (st == RX_IDLE && !en) |=> st == RX_IDLE);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/uart9_core.sv
module uart9_core
  import uart9_pkg::*;
#(
  parameter int DW        = 8,
  parameter int OVS       = 16,
  parameter int FAST_CLKS = 32,
  parameter int SLOW_CLKS = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic          slow_sel,
  input  logic          nb_par,
  input  logic          nb_val,
  input  logic          rx_en,
  input  logic          baud_tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rx_pin,
  output logic          tx_pin,
  output logic          tx_busy,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          rx_ferr,
  output logic          rx_ovr
);
  logic          tick;
  logic          nine;
  logic          fixed;
  logic          tx_b9;
  logic          r_done;
  logic [DW-1:0] r_data;
  logic          r_bit9;
  logic          r_ferr;

  assign nine  = (mode != MODE_8_EXT);
  assign fixed = (mode == MODE_9_FIX);
  assign tx_b9 = nb_par ? ^wr_data : nb_val;

  uart9_baud #(.OVS(OVS), .FAST_CLKS(FAST_CLKS), .SLOW_CLKS(SLOW_CLKS)) u_baud (
    .clk(clk), .rst(rst), .fixed(fixed), .slow(slow_sel),
    .ext_tick(baud_tick), .tick(tick)
  );

  uart9_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .nine(nine), .b9(tx_b9),
    .wr_en(wr_en), .wr_data(wr_data), .busy(tx_busy), .txd(tx_pin)
  );

  uart9_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .en(rx_en), .nine(nine),
    .rxd(rx_pin), .done(r_done), .data(r_data), .bit9(r_bit9), .ferr(r_ferr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_bit9  <= 1'b0;
      rx_ferr  <= 1'b0;
      rx_ovr   <= 1'b0;
    end else begin
      if (rd_en) begin
        rx_valid <= 1'b0;
        rx_ovr   <= 1'b0;
      end
      if (r_done) begin
        if (!rx_valid || rd_en) begin
          rx_valid <= 1'b1;
          rx_data  <= r_data;
          rx_bit9  <= r_bit9;
          rx_ferr  <= r_ferr;
        end else begin
          rx_ovr <= 1'b1;
        end
      end
    end
  end

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !r_done) |=> !rx_valid);
  assert_overrun_keeps_R10: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && r_done && !rd_en) |=> ($stable(rx_data) && rx_ovr && rx_valid));
endmodule

// File: tb/sim_uart9_core.sv
module sim_uart9_core;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int BEXT       = 16 * TDIV;
  localparam int WD_LIMIT   = 150000;
  localparam int NVEC       = 7;
  // fields: [13:12] mode, [11] slow, [10] par, [9] nb_val, [8] expected ninth, [7:0] data
  localparam logic [13:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C},
    {2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h07},
    {2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h81},
    {2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 8'h03},
    {2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF},
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h01}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic       slow_sel = 1'b0, nb_par = 1'b0, nb_val = 1'b0, rx_en = 1'b0;
  logic       baud_tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       loop = 1'b0, bb = 1'b1;
  logic       rx_pin, tx_pin, tx_busy, rx_valid, rx_bit9, rx_ferr, rx_ovr;
  logic [7:0] rx_data;
  int         n_chk = 0, n_fail = 0, cyc = 0, tdc = 0;

  assign rx_pin = loop ? tx_pin : bb;

  uart9_core u0 (
    .clk(clk), .rst(rst), .mode(mode), .slow_sel(slow_sel), .nb_par(nb_par),
    .nb_val(nb_val), .rx_en(rx_en), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rx_pin(rx_pin), .tx_pin(tx_pin),
    .tx_busy(tx_busy), .rx_valid(rx_valid), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .rx_ferr(rx_ferr), .rx_ovr(rx_ovr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    tdc       <= (tdc == TDIV - 1) ? 0 : tdc + 1;
    baud_tick <= (tdc == TDIV - 1);
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: act=%0d cycles exp<%0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_pulse();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_fall(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (tx_pin == 1'b0) begin ok = 1'b1; break; end
    end
  endtask

  task automatic decode_tx(input int bclk, input int nb, output logic [10:0] fr);
    bit ok;
    fr = '1;
    wait_fall(ok);
    if (ok) begin
      repeat (bclk / 2) @(negedge clk);
      fr[0] = tx_pin;
      for (int i = 1; i < nb; i++) begin
        repeat (bclk) @(negedge clk);
        fr[i] = tx_pin;
      end
    end
  endtask

  task automatic measure_low(output int n);
    bit ok;
    n = 0;
    wait_fall(ok);
    while (ok && tx_pin == 1'b0 && n < 2000) begin
      n = n + 1;
      @(negedge clk);
    end
  endtask

  task automatic wait_valid(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (rx_valid) begin ok = 1'b1; break; end
    end
  endtask

  task automatic bb_send(input logic [8:0] d, input int nb, input logic stopv);
    @(negedge clk);
    bb = 1'b0;
    repeat (BEXT) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      bb = d[i];
      repeat (BEXT) @(negedge clk);
    end
    bb = stopv;
    repeat (BEXT) @(negedge clk);
    bb = 1'b1;
  endtask

  initial begin
    logic [10:0] fr;
    logic [10:0] efr;
    int          lowlen;
    int          bclk;
    int          nb;
    int          lows;
    bit          ok;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 tx_pin", tx_pin, 1);
    chk("R1 tx_busy", tx_busy, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 rx_ferr", rx_ferr, 0);
    chk("R1 rx_ovr", rx_ovr, 0);

    // Vector walk: loopback frames through every mode
    loop  = 1'b1;
    rx_en = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      mode     = VEC[v][13:12];
      slow_sel = VEC[v][11];
      nb_par   = VEC[v][10];
      nb_val   = VEC[v][9];
      bclk = (VEC[v][13:12] == 2'd1) ? (VEC[v][11] ? 64 : 32) : BEXT;
      nb   = (VEC[v][13:12] == 2'd0) ? 10 : 11;
      efr  = (nb == 10) ? {1'b1, 1'b1, VEC[v][7:0], 1'b0}
                        : {1'b1, VEC[v][8], VEC[v][7:0], 1'b0};
      repeat (8) @(negedge clk);
      write_byte(VEC[v][7:0]);
      fork
        decode_tx(bclk, nb, fr);
        measure_low(lowlen);
      join
      if (nb == 10) fr[10] = 1'b1;
      chk("R2 frame bits", fr, efr);
      chk("R3 ninth bit", fr[9], efr[9]);
      if (VEC[v][0]) chk("R4 bit time", lowlen, bclk);
      wait_valid(ok);
      chk("R6 rx_valid", ok, 1);
      chk("R6 rx_data", rx_data, VEC[v][7:0]);
      chk("R6 rx_bit9", rx_bit9, (nb == 10) ? 1'b0 : VEC[v][8]);
      chk("R9 no ferr", rx_ferr, 0);
      read_pulse();
      chk("R6 cleared", rx_valid, 0);
      while (tx_busy) @(negedge clk);
    end

    // R7: receiver disabled
    loop = 1'b0; mode = 2'd2; nb_par = 1'b0; nb_val = 1'b1; rx_en = 1'b0;
    repeat (8) @(negedge clk);
    bb_send(9'h15A, 9, 1'b1);
    repeat (3 * BEXT) @(negedge clk);
    chk("R7 no reception", rx_valid, 0);

    // R9: framing error, 8-bit mode
    rx_en = 1'b1; mode = 2'd0;
    repeat (8) @(negedge clk);
    bb_send(9'h05A, 8, 1'b0);
    wait_valid(ok);
    chk("R9 valid", ok, 1);
    chk("R9 ferr", rx_ferr, 1);
    chk("R9 data", rx_data, 8'h5A);
    read_pulse();
    repeat (2 * BEXT) @(negedge clk);

    // R10: overrun keeps the held word
    bb_send(9'h011, 8, 1'b1);
    repeat (BEXT) @(negedge clk);
    bb_send(9'h022, 8, 1'b1);
    repeat (BEXT) @(negedge clk);
    chk("R10 valid held", rx_valid, 1);
    chk("R10 data kept", rx_data, 8'h11);
    chk("R10 ovr set", rx_ovr, 1);
    read_pulse();
    chk("R10 ovr cleared", rx_ovr, 0);
    chk("R10 valid cleared", rx_valid, 0);

    // R8: holding buffer, read during the next word
    mode = 2'd2; nb_par = 1'b1;
    repeat (8) @(negedge clk);
    bb_send(9'h033, 9, 1'b1);
    wait_valid(ok);
    fork
      bb_send({1'b1, 8'h44}, 9, 1'b1);
      begin
        repeat (3 * BEXT) @(negedge clk);
        chk("R8 first data", rx_data, 8'h33);
        read_pulse();
      end
    join
    wait_valid(ok);
    chk("R8 second valid", ok, 1);
    chk("R8 second data", rx_data, 8'h44);
    chk("R8 second bit9", rx_bit9, 1);
    chk("R8 no ovr", rx_ovr, 0);
    read_pulse();

    // R5: write while busy is ignored
    loop = 1'b1; mode = 2'd0;
    repeat (8) @(negedge clk);
    write_byte(8'h96);
    fork
      decode_tx(BEXT, 10, fr);
      begin
        repeat (40) @(negedge clk);
        write_byte(8'h69);
      end
    join
    fr[10] = 1'b1;
    chk("R5 first frame", fr, {1'b1, 1'b1, 8'h96, 1'b0});
    while (tx_busy) @(negedge clk);
    lows = 0;
    for (int i = 0; i < 22 * BEXT; i++) begin
      @(negedge clk);
      if (!tx_pin || tx_busy) lows = lows + 1;
    end
    chk("R5 no second frame", lows, 0);
    chk("R5 single word", rx_data, 8'h96);
    chk("R5 no overrun", rx_ovr, 0);
    read_pulse();

    // R11: transmit and receive together
    loop = 1'b0;
    repeat (8) @(negedge clk);
    fork
      begin
        write_byte(8'hC3);
        decode_tx(BEXT, 10, fr);
      end
      bb_send(9'h05E, 8, 1'b1);
    join
    fr[10] = 1'b1;
    chk("R11 tx frame", fr, {1'b1, 1'b1, 8'hC3, 1'b0});
    wait_valid(ok);
    chk("R11 rx data", rx_data, 8'h5E);

    summary();
    $finish;
  end
endmodule